// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides whether a leaf page-table entry allows a requested memory access, and prepares the entry as it should look after the access. The access is one of read, write or instruction fetch. It is made either from user mode or from supervisor mode. For supervisor accesses to ordinary pages, an authority mask from software further limits the rights. The block returns the granted rights as a 3-bit set `{exec, write, read}`. It also returns a fault flag with one-hot cause bits, which the caller can OR with the causes a table walker reports, the updated entry, and a write-back request.

The block handles one request per cycle, and each result is registered one cycle after the request. It does not write memory. When the entry has to change, it asks for the write by raising `wb_req` next to the updated entry. Write permission is only granted on a write access, which is the access that sets the change bit. After a read or a fetch the granted set leaves out write, so a later store comes back through the checker.

Top module: `page_perm_check`

## Requirements
- R1: While `rst_n` is low, `rsp_valid`, `fault`, `fault_cause`, `grant`, `pte_new` and `wb_req` are all zero.
- R2: A request presented with `req_valid` high at a clock edge produces its result with `rsp_valid` high after that edge. `rsp_valid` is low after an edge with no request.
- R3: Entry bits [5:4] hold the memory attribute, and the value 2'b10 marks non-idempotent I/O. A fetch (`acc_type` 2) to such an entry faults with only `fault_cause[0]` (guarded/no-execute) set. No permission evaluation takes place in that case.
- R4: Entry bit 3 marks a privileged page. A user-mode access (`user_mode`=1) to a privileged page gets empty rights, so it faults for every access type.
- R5: For a user-mode access, or for any access to a privileged page, the rights are entry bits [2:0], read as {exec, write, read}.
- R6: For a supervisor access to a non-privileged page, the rights are entry bits [2:0] ANDed bitwise with `amr_perm` ({exec, write, read}).
- R7: `acc_type` 0 needs read, 1 needs write and 2 needs exec. If the needed right is missing, the block faults with only `fault_cause[1]` (protection) set. On any fault `grant` is zero, `pte_new` equals the input entry and `wb_req` is low.
- R8: On success, `pte_new` is the input entry with bit 8 (reference) set and, for writes only, bit 7 (change) set. All other bits are unchanged.
- R9: On success, `grant` is the full rights for a write. For any other access it is the rights with the write bit cleared.
- R10: `wb_req` is high exactly when the result is valid, no fault occurred and `pte_new` differs from the input entry.
- R11: `acc_type` 3 is handled exactly as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| pte | input | 64 | Leaf page-table entry |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| user_mode | input | 1 | Access made in user (problem) state |
| amr_perm | input | 3 | Authority-mask rights {exec, write, read} |
| rsp_valid | output | 1 | Result valid |
| fault | output | 1 | Access denied |
| fault_cause | output | 2 | [0] guarded fetch, [1] protection |
| grant | output | 3 | Granted rights {exec, write, read} |
| pte_new | output | 64 | Entry with reference/change bits updated |
| wb_req | output | 1 | Entry changed and must be written back |

## Verification
The bench sweeps every access type, mode and authority mask against every combination of the entry's rights, privilege bit, attribute field and reference/change bits. The upper entry bits take a different pattern in each case. This sweep separates guarded fetch faults from protection faults, and user rights from rights masked by the authority mask. It also separates writes, which set the change bit and keep write rights, from reads and fetches, which drop write. Because the reference and change bits start in every state, the bench checks that a write-back is requested only when the entry actually changes.

// File: rtl/page_perm_check.sv
module page_perm_check #(
  parameter int PTE_W    = 64,
  parameter int REF_BIT  = 8,
  parameter int CHG_BIT  = 7,
  parameter int ATT_LO   = 4,
  parameter int PRIV_BIT = 3,
  parameter logic [1:0] ATT_NIO = 2'b10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [PTE_W-1:0] pte,
  input  logic [1:0]       acc_type,
  input  logic             user_mode,
  input  logic [2:0]       amr_perm,
  output logic             rsp_valid,
  output logic             fault,
  output logic [1:0]       fault_cause,
  output logic [2:0]       grant,
  output logic [PTE_W-1:0] pte_new,
  output logic             wb_req
);
  localparam logic [2:0] P_R = 3'b001;
  localparam logic [2:0] P_W = 3'b010;
  localparam logic [2:0] P_X = 3'b100;
  localparam logic [PTE_W-1:0] REF_M = PTE_W'(1) << REF_BIT;
  localparam logic [PTE_W-1:0] CHG_M = PTE_W'(1) << CHG_BIT;

  logic       is_wr, is_fx, priv, guard, denied;
  logic [2:0] eaa, perm, need;
  logic [PTE_W-1:0] upd;

  assign is_wr = (acc_type == 2'd1);
  assign is_fx = (acc_type == 2'd2);
  assign priv  = pte[PRIV_BIT];
  assign eaa   = pte[2:0];
  assign guard = is_fx && (pte[ATT_LO+1:ATT_LO] == ATT_NIO);

  always_comb begin
    if (priv && user_mode)      perm = 3'b000;
    else if (priv || user_mode) perm = eaa;
    else                        perm = eaa & amr_perm;
  end

  assign need   = is_wr ? P_W : (is_fx ? P_X : P_R);
  assign denied = !guard && ((perm & need) == 3'b000);
  assign upd    = pte | REF_M | (is_wr ? CHG_M : '0);

  logic [PTE_W-1:0] pte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      fault       <= 1'b0;
      fault_cause <= 2'b00;
      grant       <= 3'b000;
      pte_new     <= '0;
      wb_req      <= 1'b0;
      pte_q       <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        pte_q       <= pte;
        fault       <= guard | denied;
        fault_cause <= {denied, guard};
        if (guard || denied) begin
          grant   <= 3'b000;
          pte_new <= pte;
          wb_req  <= 1'b0;
        end else begin
          grant   <= is_wr ? perm : (perm & ~P_W);
          pte_new <= upd;
          wb_req  <= (upd != pte);
        end
      end else begin
        wb_req <= 1'b0;
      end
    end
  end

  // R3 R7
  cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fault_cause) && (fault == (fault_cause != 2'b00)));

  // R7
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && fault) |-> (grant == 3'b000 && !wb_req && pte_new == pte_q));

  // R8
  ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !fault) |-> pte_new[REF_BIT]);

  // R9
  wr_needs_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !fault && grant[1]) |-> pte_new[CHG_BIT]);

  // R10
  wb_only_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (wb_req == (!fault && pte_new != pte_q)));

  // R2
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
endmodule

// File: tb/test_page_perm_check.sv
module test_page_perm_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] pte = '0;
  logic [1:0]  acc_type = '0;
  logic        user_mode = 1'b0;
  logic [2:0]  amr_perm = '0;
  logic        rsp_valid, fault, wb_req;
  logic [1:0]  fault_cause;
  logic [2:0]  grant;
  logic [63:0] pte_new;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  page_perm_check i_page_perm_check (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pte(pte),
    .acc_type(acc_type), .user_mode(user_mode), .amr_perm(amr_perm),
    .rsp_valid(rsp_valid), .fault(fault), .fault_cause(fault_cause),
    .grant(grant), .pte_new(pte_new), .wb_req(wb_req)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (4000000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] p, e_pte;
    logic [2:0]  perm, need, e_grant;
    logic        guard, prot, e_fault, e_wb, wr;
    logic [1:0]  acc;
    int idx;
    string tag;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check("R1 rsp_valid", 64'(rsp_valid), 0);
    check("R1 fault", 64'(fault), 0);
    check("R1 cause", 64'(fault_cause), 0);
    check("R1 grant", 64'(grant), 0);
    check("R1 pte_new", pte_new, 0);
    check("R1 wb_req", 64'(wb_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: idle
    check("R2 idle", 64'(rsp_valid), 0);

    idx = 0;
    for (int a = 0; a < 4; a++)
    for (int u = 0; u < 2; u++)
    for (int m = 0; m < 8; m++)
    for (int lo = 0; lo < 512; lo++) begin
      acc = 2'(a);
      p = {32'hC3A5_0F1E ^ 32'(idx * 32'h9E37_79B1), 23'(idx * 7919), lo[8:0]};
      idx++;
      guard = (acc == 2'd2) && (p[5:4] == 2'b10);
      if (p[3] && u == 1)      perm = 3'b000;
      else if (p[3] || u == 1) perm = p[2:0];
      else                     perm = p[2:0] & 3'(m);
      wr   = (acc == 2'd1);
      need = wr ? 3'b010 : (acc == 2'd2 ? 3'b100 : 3'b001);
      prot = !guard && ((perm & need) == 3'b000);
      e_fault = guard | prot;
      e_grant = e_fault ? 3'b000 : (wr ? perm : (perm & 3'b101));
      e_pte   = e_fault ? p : (p | 64'h100 | (wr ? 64'h080 : 64'h0));
      e_wb    = !e_fault && (e_pte != p);

      req_valid = 1'b1; pte = p; acc_type = acc;
      user_mode = 1'(u); amr_perm = 3'(m);
      @(negedge clk);
      req_valid = 1'b0;
      if (lo == 0) check("R2 valid", 64'(rsp_valid), 1);
      if (a == 3)               tag = "R11";
      else if (guard)           tag = "R3";
      else if (p[3] && u == 1)  tag = "R4";
      else                      tag = "R7";
      check({tag, " fault"}, 64'(fault), 64'(e_fault));
      check({tag, " cause"}, 64'(fault_cause), 64'({prot, guard}));
      if (a == 3)                     tag = "R11";
      else if (p[3] || u == 1)        tag = "R5";
      else                            tag = "R6";
      check({tag, " R9 grant"}, 64'(grant), 64'(e_grant));
      check("R8 pte_new", pte_new, e_pte);
      check("R10 wb_req", 64'(wb_req), 64'(e_wb));
    end

    @(negedge clk);
    check("R2 idle after", 64'(rsp_valid), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule